// File: doc/BRIEF.md
# Strobe-Driven FIFO with Replay

This block is a first-in, first-out store for 9-bit words running on one system clock. A producer and a consumer talk to it through active-low strobes. The producer drops its write strobe and later raises it, and the word on the input bus is stored on that rising edge. The consumer drops its read strobe, sees the oldest word on the output bus with a valid indication, and consumes that word when it raises the strobe. Both strobes pass through synchronising flops, so they may come from logic that is not aligned to the clock.

Three active-low flags report how full the store is: empty, more than half full, and full. There is no handshake at the edges. The full flag is the only back-pressure on the producer, and a write that completes while the store is full is dropped. The valid output plays the part of an output enable. A read strobe on an empty store yields no valid data and consumes nothing. There is one exception: if the read strobe is held low on an empty store, the next word written appears on the output at once.

The mode input is sampled while reset is held. In standalone mode, a low pulse on the first-load/replay input moves the read pointer back to physical location zero. The block from location zero up to the write pointer can then be read again. In cascade mode, the half-full flag stays inactive and replay pulses are ignored.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low on a clock edge, both pointers and the occupancy return to zero. After release, `empty_n`=0, `half_n`=1, `full_n`=1 and `dout_valid`=0, and any earlier contents are gone.
- R2: Flags are set by the occupancy N (DEPTH words in total): N=0 gives `empty_n`=0. N from 1 to DEPTH/2 gives no flag low. N from DEPTH/2+1 to DEPTH-1 gives `half_n`=0. N=DEPTH gives `full_n`=0 and `half_n`=0. Every flag is active low.
- R3: A write whose rising strobe edge arrives while the store is full, with no read completing in the same cycle, is dropped. The write pointer and the stored contents are unchanged.
- R4: A read strobe on an empty store does not raise `dout_valid` and removes nothing.
- R5: Words leave in the order they were written, including after the pointers wrap past the last location.
- R6: In standalone mode, a low pulse on `flrt_n` sets the read pointer to zero and leaves the write pointer as it is. Occupancy becomes the number of words written since reset, capped at DEPTH, and the flags follow that number.
- R7: A replay pulse whose falling edge comes while either strobe is low, or while an access is still in progress, has no effect.
- R8: `xi` is sampled only while reset is held: 0 selects standalone and 1 selects cascade. In cascade mode, `half_n` stays 1 at every occupancy and replay pulses are ignored.
- R9: If the read strobe falls on an empty store and stays low, the first word written afterwards appears on `dout` with `dout_valid`=1. Later writes do not change `dout`. The shown word is consumed when the read strobe rises.
- R10: A write strobe that is held low while the store is full is committed on its rising edge if a read has freed a location in the meantime.
- R11: `dout_valid` is 1 only from an accepted read's falling edge to its rising edge, and it is never 1 while `empty_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| rd_n | input | 1 | Read strobe, active low; presents on falling edge, consumes on rising edge |
| flrt_n | input | 1 | First-load/replay input; a low pulse rewinds the read pointer in standalone mode |
| xi | input | 1 | Mode select sampled during reset (0 standalone, 1 cascade) |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_valid | output | 1 | Read data valid |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More-than-half flag, active low |
| empty_n | output | 1 | Empty flag, active low |

## Verification
A corrupted occupancy counter shows up on the flags three clock edges after the strobe edge that caused it, and it stays wrong for every access after that. A walk that fills and drains a small store word by word therefore catches it at the first affected level. A wrong pointer or a lost write shows up as a wrong word on `dout` on the next read that reaches that location. A wrong replay rewind shows up at once as wrong flags, and on the first replayed read as wrong data. A flow-through or held-write slip changes which word appears while the read strobe is low, or leaves the store one word short when it is drained.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Operating mode captured while reset is held
  typedef enum logic {
    MODE_CASCADE    = 1'b0,
    MODE_STANDALONE = 1'b1
  } fifo_mode_e;

  // Events derived from one synchronised active-low strobe
  typedef struct packed {
    logic fall;     // strobe went low (request)
    logic rise;     // strobe went high (completion)
    logic level_n;  // synchronised level
  } strobe_ev_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import sfifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_n,
  output strobe_ev_t ev
);

  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= {shreg[STAGES-1:0], strobe_n};
  end

  assign ev = '{
    fall:    shreg[STAGES] & ~shreg[STAGES-1],
    rise:    ~shreg[STAGES] & shreg[STAGES-1],
    level_n: shreg[STAGES-1]
  };

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter  int DW    = 9,
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic [CW-1:0] occ,
  input  logic          standalone,
  output logic          full_n,
  output logic          half_n,
  output logic          empty_n
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  always_comb begin
    full_n  = (occ != FULL_CNT);
    empty_n = (occ != '0);
    half_n  = !(standalone && (occ > HALF_CNT));
  end

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter  int DW    = 9,
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xi,
  input  strobe_ev_t    wr_ev,
  input  strobe_ev_t    rd_ev,
  input  strobe_ev_t    rt_ev,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] mem_rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic [CW-1:0] occ,
  output logic          standalone
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);

  fifo_mode_e    mode_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] occ_q, span_q;
  logic          wr_armed_q, rd_armed_q, rd_wait_q;
  logic [DW-1:0] dout_q;
  logic          valid_q;

  logic is_full, is_empty;
  logic rd_commit, wr_commit, rt_fire, flow_take;

  // the replay input only acts on its falling edge
  logic unused_rt;
  assign unused_rt = rt_ev.rise ^ rt_ev.level_n;

  always_comb begin
    is_full   = (occ_q == FULL_CNT);
    is_empty  = (occ_q == '0);
    rd_commit = rd_ev.rise && rd_armed_q;
    // a read completing in the same cycle frees the slot being written
    wr_commit = wr_ev.rise && wr_armed_q && (!is_full || rd_commit);
    rt_fire   = rt_ev.fall && (mode_q == MODE_STANDALONE)
                && wr_ev.level_n && rd_ev.level_n
                && !wr_armed_q && !rd_armed_q && !rd_wait_q;
    flow_take = wr_commit && !rd_ev.level_n
                && (rd_wait_q || (rd_ev.fall && is_empty));
  end

  // write side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      span_q     <= '0;
      wr_armed_q <= 1'b0;
    end else begin
      if (wr_ev.fall)      wr_armed_q <= 1'b1;
      else if (wr_ev.rise) wr_armed_q <= 1'b0;
      if (wr_commit) begin
        wptr_q <= wptr_q + PTR_ONE;
        if (span_q != FULL_CNT) span_q <= span_q + CNT_ONE;
      end
    end
  end

  // occupancy and mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q  <= '0;
      mode_q <= xi ? MODE_CASCADE : MODE_STANDALONE;
    end else if (rt_fire) begin
      occ_q <= span_q;
    end else if (wr_commit && !rd_commit) begin
      occ_q <= occ_q + CNT_ONE;
    end else if (!wr_commit && rd_commit) begin
      occ_q <= occ_q - CNT_ONE;
    end
  end

  // read side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q     <= '0;
      rd_armed_q <= 1'b0;
      rd_wait_q  <= 1'b0;
      valid_q    <= 1'b0;
      dout_q     <= '0;
    end else begin
      if (rt_fire)        rptr_q <= '0;
      else if (rd_commit) rptr_q <= rptr_q + PTR_ONE;

      if (rd_commit) begin
        rd_armed_q <= 1'b0;
        valid_q    <= 1'b0;
      end else if (flow_take) begin
        dout_q     <= din;
        valid_q    <= 1'b1;
        rd_armed_q <= 1'b1;
        rd_wait_q  <= 1'b0;
      end else if (rd_ev.fall) begin
        if (!is_empty) begin
          dout_q     <= mem_rdata;
          valid_q    <= 1'b1;
          rd_armed_q <= 1'b1;
        end else begin
          rd_wait_q  <= 1'b1;
        end
      end else if (rd_ev.rise) begin
        rd_wait_q <= 1'b0;
      end
    end
  end

  assign we         = wr_commit;
  assign waddr      = wptr_q;
  assign wdata      = din;
  assign raddr      = rptr_q;
  assign dout       = dout_q;
  assign dout_valid = valid_q;
  assign occ        = occ_q;
  assign standalone = (mode_q == MODE_STANDALONE);

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import sfifo_pkg::*;
#(
  parameter  int DW          = 9,
  parameter  int DEPTH       = 1024,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH),
  localparam int CW          = AW + 1,
  localparam int N_STROBES   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          flrt_n,
  input  logic          xi,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          full_n,
  output logic          half_n,
  output logic          empty_n
);

  logic [N_STROBES-1:0] strobe_n;
  strobe_ev_t           ev [N_STROBES];

  assign strobe_n = {flrt_n, rd_n, wr_n};

  for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strobe_n[g]),
      .ev       (ev[g])
    );
  end

  logic          we;
  logic [AW-1:0] wptr, rptr;
  logic [DW-1:0] wdata, mem_rdata;
  logic [CW-1:0] occ;
  logic          standalone;

  sfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (wptr),
    .wdata (wdata),
    .raddr (rptr),
    .rdata (mem_rdata)
  );

  sfifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .xi         (xi),
    .wr_ev      (ev[0]),
    .rd_ev      (ev[1]),
    .rt_ev      (ev[2]),
    .din        (din),
    .mem_rdata  (mem_rdata),
    .we         (we),
    .waddr      (wptr),
    .raddr      (rptr),
    .wdata      (wdata),
    .dout       (dout),
    .dout_valid (dout_valid),
    .occ        (occ),
    .standalone (standalone)
  );

  sfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .occ        (occ),
    .standalone (standalone),
    .full_n     (full_n),
    .half_n     (half_n),
    .empty_n    (empty_n)
  );

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] occ,
  input logic [AW-1:0] wptr,
  input logic          standalone,
  input logic          dout_valid,
  input logic          full_n,
  input logic          half_n,
  input logic          empty_n
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);

  assert_flag_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));

  assert_full_has_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && standalone) |-> !half_n);

  assert_wptr_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wptr == $past(wptr) || wptr == $past(wptr) + PTR_ONE));

  assert_cascade_no_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !standalone |-> half_n);

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(standalone));

  assert_valid_not_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> empty_n);

endmodule

bind strobe_fifo sfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .occ        (occ),
  .wptr       (wptr),
  .standalone (standalone),
  .dout_valid (dout_valid),
  .full_n     (full_n),
  .half_n     (half_n),
  .empty_n    (empty_n)
);

// File: tb/strobe_fifo_tb.sv
module strobe_fifo_tb;

  localparam int DW = 9;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          flrt_n = 1'b1;
  logic          xi = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_valid, full_n, half_n, empty_n;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  // reference model
  logic [DW-1:0] mq [D];
  int  mw, mr, mcnt, mspan;
  bit  msa;

  always #10 clk = ~clk;

  strobe_fifo #(.DW(DW), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .flrt_n(flrt_n),
    .xi(xi), .din(din), .dout(dout), .dout_valid(dout_valid),
    .full_n(full_n), .half_n(half_n), .empty_n(empty_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_flags(input string tag);
    bit ef, hf, ff;
    ff = (mcnt != D);
    hf = !(msa && mcnt > D / 2);
    ef = (mcnt != 0);
    chk(full_n == ff,  {tag, " R2 full_n"},  full_n,  ff);
    chk(half_n == hf,  {tag, " R2 half_n"},  half_n,  hf);
    chk(empty_n == ef, {tag, " R2 empty_n"}, empty_n, ef);
  endtask

  task automatic do_reset(input bit xi_v);
    wr_n = 1'b1; rd_n = 1'b1; flrt_n = 1'b1;
    xi = xi_v; rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    xi = 1'b0;
    tick(2);
    mw = 0; mr = 0; mcnt = 0; mspan = 0; msa = !xi_v;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    din = d; wr_n = 1'b0;
    tick(5);
    wr_n = 1'b1;
    tick(5);
    if (mcnt < D) begin
      mq[mw] = d; mw = (mw + 1) % D; mcnt++;
      if (mspan < D) mspan++;
    end
  endtask

  task automatic rd(input string tag);
    rd_n = 1'b0;
    tick(5);
    if (mcnt > 0) begin
      chk(dout_valid == 1'b1, {tag, " R11 valid during read"}, dout_valid, 1);
      chk(dout == mq[mr], {tag, " R5 data order"}, dout, mq[mr]);
    end else begin
      chk(dout_valid == 1'b0, {tag, " R4 empty read"}, dout_valid, 0);
    end
    rd_n = 1'b1;
    tick(5);
    chk(dout_valid == 1'b0, {tag, " R11 valid after read"}, dout_valid, 0);
    if (mcnt > 0) begin
      mr = (mr + 1) % D; mcnt--;
    end
  endtask

  task automatic rt();
    flrt_n = 1'b0;
    tick(5);
    flrt_n = 1'b1;
    tick(5);
    if (msa) begin
      mr = 0; mcnt = mspan;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    chk(empty_n == 1'b0, "R1 empty after reset", empty_n, 0);
    chk(full_n == 1'b1 && half_n == 1'b1, "R1 full/half after reset", {full_n, half_n}, 3);
    chk(dout_valid == 1'b0, "R1 valid after reset", dout_valid, 0);

    // R2 fill sweep, flag at each level
    chk_flags("fill0");
    for (int i = 0; i < D; i++) begin
      wr(DW'(9'h100 + i));
      chk_flags("fill");
    end
    // R3 write at full dropped
    wr(9'h1AA);
    chk_flags("R3 drop");
    // partial drain then replay over the whole span (R6)
    for (int i = 0; i < 3; i++) rd("pre-rt");
    chk_flags("pre-rt");
    rt();
    chk(full_n == 1'b0, "R6 full after replay", full_n, 0);
    chk_flags("R6 replay");
    for (int i = 0; i < D; i++) begin
      rd("R6 replay drain");
      chk_flags("drain");
    end
    // R4 read at empty
    rd("R4");
    chk_flags("R4 after");

    // R7 replay ignored while read strobe is low
    rd_n = 1'b0;
    tick(5);
    flrt_n = 1'b0;
    tick(5);
    flrt_n = 1'b1;
    tick(3);
    rd_n = 1'b1;
    tick(5);
    chk(empty_n == 1'b0, "R7 replay ignored", empty_n, 0);
    chk(dout_valid == 1'b0, "R7 no data", dout_valid, 0);

    // R5 pointer wrap
    for (int i = 0; i < 5; i++) wr(DW'(9'h040 + i));
    for (int i = 0; i < 5; i++) rd("R5 wrapA");
    for (int i = 0; i < 6; i++) wr(DW'(9'h080 + i));
    chk_flags("R5 wrap");
    for (int i = 0; i < 6; i++) rd("R5 wrapB");

    // R9 read flow-through
    rd_n = 1'b0;
    tick(5);
    chk(dout_valid == 1'b0, "R9 waiting", dout_valid, 0);
    wr(9'h0A5);
    chk(dout_valid == 1'b1, "R9 flow valid", dout_valid, 1);
    chk(dout == 9'h0A5, "R9 flow data", dout, 9'h0A5);
    wr(9'h05A);
    chk(dout == 9'h0A5, "R9 later write hidden", dout, 9'h0A5);
    rd_n = 1'b1;
    tick(5);
    mr = (mr + 1) % D; mcnt--;
    chk(dout_valid == 1'b0, "R9 consumed", dout_valid, 0);
    chk_flags("R9 after");
    rd("R9 second word");

    // R10 held write committed after a read frees a slot
    for (int i = 0; i < D; i++) wr(DW'(9'h120 + i));
    din = 9'h1C3; wr_n = 1'b0;
    tick(5);
    chk(full_n == 1'b0, "R10 full while held", full_n, 0);
    rd("R10 free");
    wr_n = 1'b1;
    tick(5);
    mq[mw] = 9'h1C3; mw = (mw + 1) % D; mcnt++;
    chk(full_n == 1'b0, "R10 refilled", full_n, 0);
    for (int i = 0; i < D; i++) rd("R10 drain");
    chk_flags("R10 after");

    // R1 reset discards contents
    for (int i = 0; i < 3; i++) wr(DW'(9'h010 + i));
    do_reset(1'b1);
    chk(empty_n == 1'b0, "R1 contents gone", empty_n, 0);
    rd("R1 read after reset");

    // R8 cascade mode: no half flag, replay ignored
    for (int i = 0; i < D; i++) begin
      wr(DW'(9'h0C0 + i));
      chk_flags("R8 fill");
    end
    for (int i = 0; i < 3; i++) rd("R8 part");
    rt();
    chk(full_n == 1'b1, "R8 replay ignored", full_n, 1);
    chk_flags("R8 after rt");
    for (int i = 0; i < D - 3; i++) rd("R8 drain");
    chk_flags("R8 end");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule